// File: doc/BRIEF.md
# Programmable video sync timing generator

This block derives the horizontal and vertical timing of a text overlay from a single tick clock. Each clock cycle is one 30 ns tick. A horizontal counter walks through one line and returns to zero after a programmable number of ticks. A line counter advances at each line end and wraps after a programmable number of lines. From these two counters the block drives the undelayed horizontal and vertical sync pulses, a horizontal and a vertical clamp window, and a character display window. The display window is offset from the sync origin by a line delay and by a delay counted in pixel-enable pulses.

A small write port loads a pending register set. The pending set is copied into the active set when a field ends, so the timing never changes in the middle of a field. The only exception is the write-one-to-clear status register, which acts at once. The rising edges of the undelayed syncs produce one-cycle interrupt strobes. Each strobe also sets a sticky status bit. A configuration flag is raised when the horizontal display delay, multiplied by the programmed pixel period, does not exceed the minimum time.

The vertical position is tracked by a four-state machine. The states are V_SYNC (sync lines), V_TOP (lines before the display), V_ACTIVE (display lines) and V_BOTTOM (remaining lines). All transitions happen at a line end:
- T_SYNC_DONE leaves V_SYNC for V_TOP once the next line is at or past VS_LINES.
- T_SYNC_SKIP goes from V_SYNC straight to V_ACTIVE or V_BOTTOM when the delay has already been reached.
- T_TOP_DONE goes from V_TOP to V_ACTIVE when the next line equals the delay.
- T_ACTIVE_DONE goes from V_ACTIVE to V_BOTTOM when the next line equals delay plus height.
- T_WRAP goes from any state to V_SYNC when the next line is line 0.

Top module: `vsg_top`

## Requirements
- R1: While reset is applied, every register takes its reset value and both counters return to zero. In that state hsync and vsync read 1; h_irq, v_irq, irq_status and cfg_err read 0; the clamp outputs are low unless their begin value is 0.
- R2: The horizontal counter spans (register 1) + 1 ticks. h_irq pulses once per line, at tick 0. hsync is high for ticks 0 to HS_TICKS-1 of every line.
- R3: A field spans (register 0) + 1 lines. v_irq pulses once per field, at tick 0 of line 0. vsync is high for lines 0 to VS_LINES-1.
- R4: hclamp is high while the tick count is at or above 16 × (register 6) and below 16 × (register 7). When begin is at or above end, hclamp stays low.
- R5: vclamp is high on lines at or above register 4 and below register 5.
- R6: disp_win is high on lines from register 2 up to (register 2 + register 9), end excluded. Within those lines it is high while the count of pix_en pulses since the line started lies from register 3 up to (register 3 + register 8), end excluded. With pix_en held low the window never opens.
- R7: h_irq and v_irq are single-cycle strobes on the rising edges of hsync and vsync. Each v_irq coincides with an h_irq.
- R8: irq_status bit 0 is set by h_irq and bit 1 by v_irq, one cycle after the strobe. Writing to address 11 clears the bits whose data bits are 1. A data bit of 0 leaves the status bit unchanged. A strobe in the same cycle as a clear wins.
- R9: Registers 0 to 10 are written into a pending set. The pending set becomes active only when the current field ends.
- R10: cfg_err becomes 1 one cycle after a pending write makes (register 3) × (register 10, the pixel period in ns) at or below MIN_HDELAY_NS. It becomes 0 once the product exceeds that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one cycle per 30 ns tick |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | One-cycle pixel pulse used for the horizontal display delay |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| hsync | output | 1 | Undelayed horizontal sync pulse |
| vsync | output | 1 | Undelayed vertical sync pulse |
| hclamp | output | 1 | Horizontal clamp window |
| vclamp | output | 1 | Vertical clamp window |
| disp_win | output | 1 | Character display window |
| h_irq | output | 1 | Horizontal interrupt strobe |
| v_irq | output | 1 | Vertical interrupt strobe |
| irq_status | output | 2 | Sticky interrupt flags, bit 1 vertical, bit 0 horizontal |
| cfg_err | output | 1 | Horizontal delay too short for the pixel period |

## Verification
The bench builds the block with HS_TICKS=4 and VS_LINES=2. It also overrides the reset values to give a 40-tick line and a 10-line field: display lines 4 to 6, pixels 8 to 17, clamp ticks 16 to 31, clamp lines 1 to 2, and a 300 ns pixel period. With these values a whole field lasts 400 cycles, so the bench can check every cycle of a field against computed positions. The pending-to-active handover and the field-length change after a write also fall within a few hundred cycles. The widths and the MIN_HDELAY_NS threshold stay at their defaults, so the cfg_err boundary at exactly 2000 ns can be reached with small delay values.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

    localparam int LINE_W  = 10;   // line counter, 1..1024 lines
    localparam int VREG_W  = 11;   // line-valued registers up to 1024
    localparam int TICK_W  = 12;   // tick counter and pixel-valued fields
    localparam int HSTEP_W = 9;    // clamp steps of 16 ticks
    localparam int HSTEP_SH = 4;   // log2 of ticks per clamp step

    localparam logic [3:0] ADDR_LINES  = 4'd0;
    localparam logic [3:0] ADDR_HPER   = 4'd1;
    localparam logic [3:0] ADDR_VDLY   = 4'd2;
    localparam logic [3:0] ADDR_HDLY   = 4'd3;
    localparam logic [3:0] ADDR_VCB    = 4'd4;
    localparam logic [3:0] ADDR_VCE    = 4'd5;
    localparam logic [3:0] ADDR_HCB    = 4'd6;
    localparam logic [3:0] ADDR_HCE    = 4'd7;
    localparam logic [3:0] ADDR_WIN_W  = 4'd8;
    localparam logic [3:0] ADDR_WIN_H  = 4'd9;
    localparam logic [3:0] ADDR_PIXNS  = 4'd10;
    localparam logic [3:0] ADDR_STATUS = 4'd11;

    typedef enum logic [1:0] {
        V_SYNC,
        V_TOP,
        V_ACTIVE,
        V_BOTTOM
    } vregion_e;

    typedef struct packed {
        logic [LINE_W-1:0]  lines_m1;
        logic [TICK_W-1:0]  hper_m1;
        logic [VREG_W-1:0]  vdelay;
        logic [TICK_W-1:0]  hdelay;
        logic [VREG_W-1:0]  vcb;
        logic [VREG_W-1:0]  vce;
        logic [HSTEP_W-1:0] hcb;
        logic [HSTEP_W-1:0] hce;
        logic [TICK_W-1:0]  win_w;
        logic [LINE_W-1:0]  win_h;
        logic [TICK_W-1:0]  pix_ns;
    } cfg_t;

endpackage

// File: rtl/vsg_regs.sv
module vsg_regs
    import vsg_pkg::*;
#(
    parameter cfg_t RST_CFG       = '0,
    parameter int   MIN_HDELAY_NS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [TICK_W-1:0] wr_data,
    input  logic              field_end,
    output cfg_t              act,
    output logic [1:0]        status_clr,
    output logic              cfg_err
);

    localparam int PROD_W = 2 * TICK_W;
    localparam logic [PROD_W-1:0] MIN_PROD = PROD_W'(MIN_HDELAY_NS);

    cfg_t shd;
    logic [PROD_W-1:0] delay_prod;

    assign delay_prod = PROD_W'(shd.hdelay) * PROD_W'(shd.pix_ns);
    assign status_clr = (wr_en && (wr_addr == ADDR_STATUS)) ? wr_data[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            shd <= RST_CFG;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_LINES: shd.lines_m1 <= wr_data[LINE_W-1:0];
                ADDR_HPER:  shd.hper_m1  <= wr_data;
                ADDR_VDLY:  shd.vdelay   <= wr_data[VREG_W-1:0];
                ADDR_HDLY:  shd.hdelay   <= wr_data;
                ADDR_VCB:   shd.vcb      <= wr_data[VREG_W-1:0];
                ADDR_VCE:   shd.vce      <= wr_data[VREG_W-1:0];
                ADDR_HCB:   shd.hcb      <= wr_data[HSTEP_W-1:0];
                ADDR_HCE:   shd.hce      <= wr_data[HSTEP_W-1:0];
                ADDR_WIN_W: shd.win_w    <= wr_data;
                ADDR_WIN_H: shd.win_h    <= wr_data[LINE_W-1:0];
                ADDR_PIXNS: shd.pix_ns   <= wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= RST_CFG;
        end else if (field_end) begin
            act <= shd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= (delay_prod <= MIN_PROD);
        end
    end

endmodule

// File: rtl/vsg_hcount.sv
module vsg_hcount
    import vsg_pkg::*;
#(
    parameter int HS_TICKS = 157
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_en,
    input  logic [TICK_W-1:0]  hper_m1,
    input  logic [HSTEP_W-1:0] hcb,
    input  logic [HSTEP_W-1:0] hce,
    input  logic [TICK_W-1:0]  hdelay,
    input  logic [TICK_W-1:0]  win_w,
    output logic               line_end,
    output logic               hsync,
    output logic               hclamp,
    output logic               hwin
);

    localparam int EXT_W = TICK_W + 1;
    localparam logic [TICK_W-1:0] HS_END = TICK_W'(HS_TICKS);
    localparam logic [TICK_W-1:0] PCNT_MAX = '1;

    logic [TICK_W-1:0] hcnt;
    logic [TICK_W-1:0] pcnt;
    logic [EXT_W-1:0]  hc_beg, hc_end, win_beg, win_end;

    assign hc_beg  = {hcb, {HSTEP_SH{1'b0}}};
    assign hc_end  = {hce, {HSTEP_SH{1'b0}}};
    assign win_beg = {1'b0, hdelay};
    assign win_end = {1'b0, hdelay} + {1'b0, win_w};

    assign line_end = (hcnt >= hper_m1);

    always_ff @(posedge clk) begin
        if (rst || line_end) begin
            hcnt <= '0;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || line_end) begin
            pcnt <= '0;
        end else if (pix_en && (pcnt != PCNT_MAX)) begin
            pcnt <= pcnt + 1'b1;
        end
    end

    always_comb begin
        hsync  = (hcnt < HS_END);
        hclamp = ({1'b0, hcnt} >= hc_beg) && ({1'b0, hcnt} < hc_end);
        hwin   = ({1'b0, pcnt} >= win_beg) && ({1'b0, pcnt} < win_end);
    end

endmodule

// File: rtl/vsg_vfsm.sv
module vsg_vfsm
    import vsg_pkg::*;
#(
    parameter int VS_LINES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic [LINE_W-1:0] lines_m1,
    input  logic [VREG_W-1:0] vdelay,
    input  logic [LINE_W-1:0] win_h,
    input  logic [VREG_W-1:0] vcb,
    input  logic [VREG_W-1:0] vce,
    output logic              field_end,
    output logic              vsync,
    output logic              vclamp,
    output logic              vwin
);

    localparam int EXT_W = VREG_W + 1;
    localparam logic [EXT_W-1:0] VS_END = EXT_W'(VS_LINES);

    vregion_e          state, state_nxt;
    logic [LINE_W-1:0] lcnt, lnext;
    logic [EXT_W-1:0]  nl_ext, dly_ext, vend;

    assign field_end = line_end && (lcnt >= lines_m1);
    assign lnext     = (lcnt >= lines_m1) ? '0 : lcnt + 1'b1;
    assign nl_ext    = EXT_W'(lnext);
    assign dly_ext   = EXT_W'(vdelay);
    assign vend      = EXT_W'(vdelay) + EXT_W'(win_h);

    always_ff @(posedge clk) begin
        if (rst) begin
            lcnt <= '0;
        end else if (line_end) begin
            lcnt <= lnext;
        end
    end

    always_comb begin
        state_nxt = state;
        if (line_end) begin
            if (lnext == '0) begin
                state_nxt = V_SYNC;                          // T_WRAP
            end else begin
                unique case (state)
                    V_SYNC: begin
                        if (nl_ext >= VS_END) begin
                            if (nl_ext < dly_ext) begin
                                state_nxt = V_TOP;           // T_SYNC_DONE
                            end else if (nl_ext < vend) begin
                                state_nxt = V_ACTIVE;        // T_SYNC_SKIP
                            end else begin
                                state_nxt = V_BOTTOM;        // T_SYNC_SKIP
                            end
                        end
                    end
                    V_TOP: begin
                        if (nl_ext >= dly_ext) begin
                            state_nxt = (nl_ext < vend) ? V_ACTIVE : V_BOTTOM; // T_TOP_DONE
                        end
                    end
                    V_ACTIVE: begin
                        if (nl_ext >= vend) begin
                            state_nxt = V_BOTTOM;            // T_ACTIVE_DONE
                        end
                    end
                    V_BOTTOM: state_nxt = V_BOTTOM;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= V_SYNC;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        vsync = 1'b0;
        vwin  = 1'b0;
        unique case (state)
            V_SYNC:   vsync = 1'b1;
            V_TOP:    ;
            V_ACTIVE: vwin  = 1'b1;
            V_BOTTOM: ;
        endcase
        vclamp = ({1'b0, lcnt} >= vcb) && ({1'b0, lcnt} < vce);
    end

endmodule

// File: rtl/vsg_top.sv
module vsg_top
    import vsg_pkg::*;
#(
    parameter int HS_TICKS      = 157,
    parameter int VS_LINES      = 3,
    parameter int MIN_HDELAY_NS = 2000,
    parameter int RST_LINES_M1  = 624,
    parameter int RST_HPER_M1   = 2132,
    parameter int RST_VDELAY    = 32,
    parameter int RST_HDELAY    = 72,
    parameter int RST_VCB       = 0,
    parameter int RST_VCE       = 4,
    parameter int RST_HCB       = 0,
    parameter int RST_HCE       = 10,
    parameter int RST_WIN_W     = 480,
    parameter int RST_WIN_H     = 250,
    parameter int RST_PIX_NS    = 83
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pix_en,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [11:0] wr_data,
    output logic        hsync,
    output logic        vsync,
    output logic        hclamp,
    output logic        vclamp,
    output logic        disp_win,
    output logic        h_irq,
    output logic        v_irq,
    output logic [1:0]  irq_status,
    output logic        cfg_err
);

    localparam cfg_t RST_CFG = '{
        lines_m1: LINE_W'(RST_LINES_M1),
        hper_m1:  TICK_W'(RST_HPER_M1),
        vdelay:   VREG_W'(RST_VDELAY),
        hdelay:   TICK_W'(RST_HDELAY),
        vcb:      VREG_W'(RST_VCB),
        vce:      VREG_W'(RST_VCE),
        hcb:      HSTEP_W'(RST_HCB),
        hce:      HSTEP_W'(RST_HCE),
        win_w:    TICK_W'(RST_WIN_W),
        win_h:    LINE_W'(RST_WIN_H),
        pix_ns:   TICK_W'(RST_PIX_NS)
    };

    cfg_t       act;
    logic [1:0] status_clr;
    logic       field_end, line_end;
    logic       hwin, vwin;
    logic       hsync_q, vsync_q;

    vsg_regs #(
        .RST_CFG      (RST_CFG),
        .MIN_HDELAY_NS(MIN_HDELAY_NS)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .field_end (field_end),
        .act       (act),
        .status_clr(status_clr),
        .cfg_err   (cfg_err)
    );

    vsg_hcount #(
        .HS_TICKS(HS_TICKS)
    ) u_hcount (
        .clk     (clk),
        .rst     (rst),
        .pix_en  (pix_en),
        .hper_m1 (act.hper_m1),
        .hcb     (act.hcb),
        .hce     (act.hce),
        .hdelay  (act.hdelay),
        .win_w   (act.win_w),
        .line_end(line_end),
        .hsync   (hsync),
        .hclamp  (hclamp),
        .hwin    (hwin)
    );

    vsg_vfsm #(
        .VS_LINES(VS_LINES)
    ) u_vfsm (
        .clk      (clk),
        .rst      (rst),
        .line_end (line_end),
        .lines_m1 (act.lines_m1),
        .vdelay   (act.vdelay),
        .win_h    (act.win_h),
        .vcb      (act.vcb),
        .vce      (act.vce),
        .field_end(field_end),
        .vsync    (vsync),
        .vclamp   (vclamp),
        .vwin     (vwin)
    );

    // Edge history resets high so the sync level present at reset raises no strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_q <= 1'b1;
            vsync_q <= 1'b1;
        end else begin
            hsync_q <= hsync;
            vsync_q <= vsync;
        end
    end

    assign h_irq    = hsync & ~hsync_q;
    assign v_irq    = vsync & ~vsync_q;
    assign disp_win = hwin & vwin;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status <= 2'b00;
        end else begin
            irq_status <= (irq_status & ~status_clr) | {v_irq, h_irq};
        end
    end

endmodule

// File: rtl/vsg_chk.sv
module vsg_chk (
    input logic       clk,
    input logic       rst,
    input logic       vsync,
    input logic       disp_win,
    input logic       h_irq,
    input logic       v_irq,
    input logic [1:0] irq_status
);

    // R7
    h_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        h_irq |=> !h_irq);

    // R7
    v_irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        v_irq |=> !v_irq);

    // R7
    v_irq_line_start_chk: assert property (@(posedge clk) disable iff (rst)
        v_irq |-> h_irq);

    // R8
    h_status_set_chk: assert property (@(posedge clk) disable iff (rst)
        h_irq |=> irq_status[0]);

    // R8
    v_status_set_chk: assert property (@(posedge clk) disable iff (rst)
        v_irq |=> irq_status[1]);

    // R6
    win_outside_sync_chk: assert property (@(posedge clk) disable iff (rst)
        disp_win |-> !vsync);

endmodule

bind vsg_top vsg_chk u_vsg_chk (
    .clk       (clk),
    .rst       (rst),
    .vsync     (vsync),
    .disp_win  (disp_win),
    .h_irq     (h_irq),
    .v_irq     (v_irq),
    .irq_status(irq_status)
);

// File: tb/tb_vsg_top.sv
module tb_vsg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        hsync, vsync, hclamp, vclamp, disp_win, h_irq, v_irq, cfg_err;
    logic [1:0]  irq_status;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int LINE_T = 40;
    localparam int NLINES = 10;

    always #5 clk = ~clk;

    vsg_top #(
        .HS_TICKS(4), .VS_LINES(2),
        .RST_LINES_M1(9), .RST_HPER_M1(39),
        .RST_VDELAY(4), .RST_HDELAY(8),
        .RST_VCB(1), .RST_VCE(3),
        .RST_HCB(1), .RST_HCE(2),
        .RST_WIN_W(10), .RST_WIN_H(3),
        .RST_PIX_NS(300)
    ) dut (
        .clk(clk), .rst(rst), .pix_en(pix_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .hclamp(hclamp), .vclamp(vclamp),
        .disp_win(disp_win), .h_irq(h_irq), .v_irq(v_irq),
        .irq_status(irq_status), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_reg(input int addr, input int data);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 12'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_h();
        int n = 0;
        @(negedge clk);
        while (!h_irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (!h_irq) chk("R2 h_irq timeout", 0, 1);
    endtask

    task automatic wait_v();
        int n = 0;
        @(negedge clk);
        while (!v_irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!v_irq) chk("R3 v_irq timeout", 0, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 hsync", int'(hsync), 1);
        chk("R1 vsync", int'(vsync), 1);
        chk("R1 h_irq", int'(h_irq), 0);
        chk("R1 v_irq", int'(v_irq), 0);
        chk("R1 irq_status", int'(irq_status), 0);
        chk("R1 cfg_err", int'(cfg_err), 0);
        chk("R1 hclamp", int'(hclamp), 0);
        chk("R1 vclamp", int'(vclamp), 0);
        chk("R1 disp_win", int'(disp_win), 0);
    endtask

    task automatic t_horizontal();
        wait_h();
        for (int j = 0; j <= LINE_T; j++) begin
            int p = j % LINE_T;
            chk("R2 hsync", int'(hsync), int'(p < 4));
            chk("R7 h_irq", int'(h_irq), int'(p == 0));
            chk("R4 hclamp", int'(hclamp), int'(p >= 16 && p < 32));
            if (j < LINE_T) @(negedge clk);
        end
    endtask

    task automatic t_field();
        wait_v();
        for (int pos = 0; pos <= LINE_T * NLINES; pos++) begin
            int l = (pos / LINE_T) % NLINES;
            int j = pos % LINE_T;
            chk("R3 vsync", int'(vsync), int'(l < 2));
            chk("R3 v_irq", int'(v_irq), int'(pos % (LINE_T * NLINES) == 0));
            chk("R5 vclamp", int'(vclamp), int'(l >= 1 && l < 3));
            chk("R6 disp_win", int'(disp_win),
                int'(l >= 4 && l < 7 && j >= 8 && j < 18));
            if (pos < LINE_T * NLINES) @(negedge clk);
        end
    endtask

    task automatic t_no_pixels();
        pix_en = 1'b0;
        wait_v();
        for (int pos = 0; pos < LINE_T * NLINES; pos++) begin
            chk("R6 disp_win without pix_en", int'(disp_win), 0);
            @(negedge clk);
        end
        pix_en = 1'b1;
    endtask

    task automatic t_status();
        wait_h();
        @(negedge clk);
        chk("R8 status set", int'(irq_status[0]), 1);
        write_reg(11, 0);
        chk("R8 zero write keeps", int'(irq_status[0]), 1);
        write_reg(11, 1);
        chk("R8 clear bit0", int'(irq_status[0]), 0);
        wait_v();
        @(negedge clk);
        chk("R8 v status set", int'(irq_status[1]), 1);
        write_reg(11, 3);
        chk("R8 clear both", int'(irq_status), 0);
    endtask

    task automatic t_cfg();
        write_reg(3, 6);
        @(negedge clk);
        chk("R10 6x300 flags", int'(cfg_err), 1);
        write_reg(10, 400);
        @(negedge clk);
        chk("R10 6x400 clear", int'(cfg_err), 0);
        write_reg(3, 5);
        @(negedge clk);
        chk("R10 5x400 boundary", int'(cfg_err), 1);
        write_reg(3, 8);
        @(negedge clk);
        chk("R10 8x400 clear", int'(cfg_err), 0);
    endtask

    task automatic t_clamp_empty();
        write_reg(6, 2);
        wait_v();
        for (int j = 0; j < LINE_T; j++) begin
            chk("R4 begin==end no clamp", int'(hclamp), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_shadow();
        int n;
        wait_v();
        write_reg(0, 5);
        n = 1;
        while (!v_irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 current field unchanged", n, LINE_T * NLINES);
        n = 0;
        @(negedge clk);
        n = 1;
        while (!v_irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R9 next field uses new count", n, LINE_T * 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_horizontal();
        t_field();
        t_no_pixels();
        t_status();
        t_cfg();
        t_clamp_empty();
        t_shadow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule